// File: doc/BRIEF.md
# Register-Programmed Raster Timing Generator

This block produces the horizontal and vertical raster timing for a display pipeline. Software sets up a small register file: a pair of boundaries for each of the active, blanking and sync regions on both axes, a configuration word, a line pitch, a line size and a protection lock. From these values, a pixel counter and a line counter produce the active-display enable, the blank, hsync and vsync, and a one-clock request that tells a memory fetch unit to read the next framebuffer line.

Each timing register holds two values, each stored as the count minus one. The low half is the start value or the active count. The high half is the end value or the total. Writes reach the protected registers only after the unlock key has been written to the lock register. The raster runs only while the generator-enable bit is set. Before reprogramming, software clears that bit. Timing values are copied into the working copy only at the start of a frame, so a change made mid-frame never tears the picture.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the lock is closed, every register reads 0, both counters are 0, and de, blank, hsync, vsync and fetch_req are low.
- R2: Address 0 is the lock. Writing 32'h0000_4758 there opens it, and writing any other value closes it. A read of address 0 returns 1 when open and 0 when closed. While the lock is closed, writes to addresses 1 to 9 leave their contents unchanged.
- R3: The register map is as follows. Address 1 is the configuration word: bit 0 enables the generator and bit 1 enables graphics data. Addresses 2, 3 and 4 are the horizontal active/total, blank start/end and sync start/end words. Addresses 5, 6 and 7 are the same three words for the vertical axis. Address 8 is the pitch and address 9 is the line size. In each timing word, bits 15:0 hold the first value and bits 31:16 the second. A read presents the stored word on rd_data one clock after the address is applied. Unmapped addresses read 0.
- R4: While the enable bit is clear, de, blank, hsync, vsync and fetch_req are low. From the clock after the bit clears, pix_x and line_y read 0.
- R5: While enabled, pix_x runs from 0 up to the horizontal total and then wraps to 0. line_y advances at each pix_x wrap and wraps to 0 after the vertical total.
- R6: de is high when pix_x is at most the horizontal active value, line_y is at most the vertical active value, and configuration bit 1 is set. With bit 1 clear, de stays low while the other timing keeps running.
- R7: blank is high when pix_x is above the horizontal blank start and at most the blank end, or when line_y meets the same test against the vertical blank values.
- R8: hsync is high when pix_x lies between the horizontal sync start and end, inclusive. vsync follows the same rule on line_y, so it changes only where pix_x wraps.
- R9: fetch_req is high for one clock when pix_x equals the horizontal active value plus one. This happens on lines below the vertical active value and on the last line of the frame. fetch_pitch and fetch_size carry bits 15:0 of addresses 8 and 9.
- R10: Timing words written while the generator runs take effect only at the next frame start. Until then the current frame keeps its old geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address for write and read |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Registered read data |
| pix_x | output | CW | Horizontal position counter |
| line_y | output | CW | Vertical line counter |
| de | output | 1 | Active-display enable |
| blank | output | 1 | Blanking interval |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| fetch_req | output | 1 | One-clock line fetch request |
| fetch_pitch | output | PW | Line pitch in 8-byte units |
| fetch_size | output | PW | Line fetch length in 8-byte units |

## Verification
A wrong counter value appears on pix_x and line_y in the same cycle, because both are direct ports. It then shifts every decoded output by the same offset until the next wrap. A wrong working copy of the timing values stays hidden until it changes the frame geometry: a wrong total shows at the first line wrap, and a wrong vertical value shows within one frame. A wrong lock state appears one clock after a read of address 0, and on any protected register read back after an attempted write.

// File: rtl/dtg_pkg.sv
// Shared constants and types for the raster timing generator.
// Assumes a 32-bit register word carrying two 16-bit fields.
package dtg_pkg;
    localparam int DW = 32;
    localparam int FW = 16;
    localparam logic [DW-1:0] UNLOCK_KEY = 32'h0000_4758;

    localparam int ADDR_LOCK  = 0;
    localparam int ADDR_CFG   = 1;
    localparam int ADDR_HACT  = 2;
    localparam int ADDR_VACT  = 5;
    localparam int ADDR_PITCH = 8;
    localparam int ADDR_LSIZE = 9;
    localparam int NTIM       = 6;

    localparam int CFG_RUN_BIT = 0;
    localparam int CFG_GFX_BIT = 1;

    // Per-axis timing values, each stored as count minus one
    typedef struct packed {
        logic [FW-1:0] act;
        logic [FW-1:0] tot;
        logic [FW-1:0] bs;
        logic [FW-1:0] be;
        logic [FW-1:0] ss;
        logic [FW-1:0] se;
    } axis_t;
endpackage

// File: rtl/dtg_regfile.sv
// Register file with write lock for the raster timing generator.
// Holds the lock state, the configuration bits, six timing words, the pitch
// and the line size. The lock register itself can always be written.
// A read is registered and returns the stored word one clock later.
module dtg_regfile
    import dtg_pkg::*;
#(
    parameter int AW = 4,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          unlocked,
    output logic          tgen_en,
    output logic          gfx_en,
    output axis_t         h_prog,
    output axis_t         v_prog,
    output logic [PW-1:0] pitch,
    output logic [PW-1:0] lsize
);
    logic [1:0]    cfg_q;
    logic [PW-1:0] pitch_q;
    logic [PW-1:0] lsize_q;
    logic [DW-1:0] tim_q [NTIM];
    logic          wr_ok;
    logic [DW-1:0] rd_mux;

    assign wr_ok = wr_en && unlocked;

    // Lock state: the key opens it, any other value closes it
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked <= 1'b0;
        else if (wr_en && addr == AW'(ADDR_LOCK))
            unlocked <= (wr_data == UNLOCK_KEY);
    end

    // Configuration, pitch and size registers, written only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            pitch_q <= '0;
            lsize_q <= '0;
        end else if (wr_ok) begin
            if (addr == AW'(ADDR_CFG))   cfg_q   <= wr_data[1:0];
            if (addr == AW'(ADDR_PITCH)) pitch_q <= wr_data[PW-1:0];
            if (addr == AW'(ADDR_LSIZE)) lsize_q <= wr_data[PW-1:0];
        end
    end

    // Timing words, written only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTIM; i++) tim_q[i] <= '0;
        end else if (wr_ok) begin
            for (int i = 0; i < NTIM; i++)
                if (addr == AW'(ADDR_HACT + i)) tim_q[i] <= wr_data;
        end
    end

    // Read selection
    always_comb begin
        rd_mux = '0;
        if (addr == AW'(ADDR_LOCK))  rd_mux = {{(DW-1){1'b0}}, unlocked};
        if (addr == AW'(ADDR_CFG))   rd_mux = {{(DW-2){1'b0}}, cfg_q};
        if (addr == AW'(ADDR_PITCH)) rd_mux = DW'(pitch_q);
        if (addr == AW'(ADDR_LSIZE)) rd_mux = DW'(lsize_q);
        for (int i = 0; i < NTIM; i++)
            if (addr == AW'(ADDR_HACT + i)) rd_mux = tim_q[i];
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_mux;
    end

    assign tgen_en = cfg_q[CFG_RUN_BIT];
    assign gfx_en  = cfg_q[CFG_GFX_BIT];
    assign pitch   = pitch_q;
    assign lsize   = lsize_q;

    // Unpack the timing words: low half first value, high half second value
    assign h_prog = '{act: tim_q[0][FW-1:0], tot: tim_q[0][DW-1:FW],
                      bs:  tim_q[1][FW-1:0], be:  tim_q[1][DW-1:FW],
                      ss:  tim_q[2][FW-1:0], se:  tim_q[2][DW-1:FW]};
    assign v_prog = '{act: tim_q[3][FW-1:0], tot: tim_q[3][DW-1:FW],
                      bs:  tim_q[4][FW-1:0], be:  tim_q[4][DW-1:FW],
                      ss:  tim_q[5][FW-1:0], se:  tim_q[5][DW-1:FW]};
endmodule

// File: rtl/dtg_axis.sv
// One raster axis: a working copy of the timing values plus a counter and
// region decode. The counter holds at zero while run is low and advances on
// step, wrapping after the total. The working copy is reloaded when load is high.
// Assumes CW is wide enough for the programmed totals.
module dtg_axis
    import dtg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic          load,
    input  axis_t         prog,
    output logic [CW-1:0] cnt,
    output logic          last,
    output logic          in_act,
    output logic          in_blank,
    output logic          in_sync,
    output logic          blank_start,
    output logic          pre_active
);
    axis_t         work;
    logic [CW-1:0] act_c, tot_c, bs_c, be_c, ss_c, se_c;

    // Working copy of the timing values, refreshed only at frame start
    always_ff @(posedge clk) begin
        if (!rst_n)    work <= '0;
        else if (load) work <= prog;
    end

    assign act_c = CW'(work.act);
    assign tot_c = CW'(work.tot);
    assign bs_c  = CW'(work.bs);
    assign be_c  = CW'(work.be);
    assign ss_c  = CW'(work.ss);
    assign se_c  = CW'(work.se);

    // Position counter with wrap at the total
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (step)      cnt <= last ? '0 : cnt + 1'b1;
    end

    assign last        = (cnt == tot_c);
    assign in_act      = (cnt <= act_c);
    assign in_blank    = (cnt > bs_c) && (cnt <= be_c);
    assign in_sync     = (cnt >= ss_c) && (cnt <= se_c);
    assign blank_start = ({1'b0, cnt} == ({1'b0, act_c} + 1'b1));
    assign pre_active  = last || (cnt < act_c);
endmodule

// File: rtl/disp_timing_gen.sv
// Register-programmed raster timing generator, top level.
// Joins the register file to a horizontal and a vertical axis. The vertical
// axis steps at each horizontal wrap, and both working copies reload at frame
// start or while the generator is disabled. Outputs are gated by the enable bit.
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int AW = 4,
    parameter int CW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wr_data,
    output logic [31:0]   rd_data,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] line_y,
    output logic          de,
    output logic          blank,
    output logic          hsync,
    output logic          vsync,
    output logic          fetch_req,
    output logic [PW-1:0] fetch_pitch,
    output logic [PW-1:0] fetch_size
);
    logic  unlocked, tgen_en, gfx_en;
    axis_t h_prog, v_prog;
    logic  frame_load;
    logic  h_last, h_act, h_blank, h_sync, h_bstart, h_pre;
    logic  v_last, v_act, v_blank, v_sync, v_bstart, v_pre;

    dtg_regfile #(.AW(AW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .unlocked(unlocked),
        .tgen_en(tgen_en), .gfx_en(gfx_en), .h_prog(h_prog), .v_prog(v_prog),
        .pitch(fetch_pitch), .lsize(fetch_size)
    );

    // Reload the timing values while idle or on the last pixel of a frame
    assign frame_load = !tgen_en || (h_last && v_last);

    dtg_axis #(.CW(CW)) u_h (
        .clk(clk), .rst_n(rst_n), .run(tgen_en), .step(1'b1), .load(frame_load),
        .prog(h_prog), .cnt(pix_x), .last(h_last), .in_act(h_act),
        .in_blank(h_blank), .in_sync(h_sync), .blank_start(h_bstart),
        .pre_active(h_pre)
    );

    dtg_axis #(.CW(CW)) u_v (
        .clk(clk), .rst_n(rst_n), .run(tgen_en), .step(h_last), .load(frame_load),
        .prog(v_prog), .cnt(line_y), .last(v_last), .in_act(v_act),
        .in_blank(v_blank), .in_sync(v_sync), .blank_start(v_bstart),
        .pre_active(v_pre)
    );

    // Output decode, all forced inactive while the generator is disabled
    always_comb begin
        de        = tgen_en && gfx_en && h_act && v_act;
        blank     = tgen_en && (h_blank || v_blank);
        hsync     = tgen_en && h_sync;
        vsync     = tgen_en && v_sync;
        fetch_req = tgen_en && h_bstart && v_pre;
    end
endmodule

// File: rtl/dtg_checker.sv
// Temporal properties of the raster timing generator, bound to the top.
// Observes ports plus the enable, graphics and lock state from the register file.
module dtg_checker #(
    parameter int AW = 4,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          tgen_en,
    input logic          gfx_en,
    input logic          unlocked,
    input logic [CW-1:0] pix_x,
    input logic [CW-1:0] line_y,
    input logic          de,
    input logic          blank,
    input logic          hsync,
    input logic          vsync,
    input logic          fetch_req
);
    // R4
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tgen_en |=> (pix_x == '0) && (line_y == '0));

    // R4
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tgen_en |-> !de && !blank && !hsync && !vsync && !fetch_req);

    // R2
    locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && wr_en) |=> $stable(tgen_en) && $stable(gfx_en));

    // R5
    pixel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgen_en && $past(tgen_en) && pix_x != '0) |-> pix_x == $past(pix_x) + 1'b1);

    // R8
    vsync_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgen_en && $past(tgen_en) && pix_x != '0) |-> $stable(vsync));

    // R9
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    // R6
    de_gfx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> gfx_en);
endmodule

bind disp_timing_gen dtg_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tgen_en(tgen_en),
    .gfx_en(gfx_en), .unlocked(unlocked), .pix_x(pix_x), .line_y(line_y),
    .de(de), .blank(blank), .hsync(hsync), .vsync(vsync), .fetch_req(fetch_req)
);

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int CW = 16;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [CW-1:0] pix_x, line_y;
    logic          de, blank, hsync, vsync, fetch_req;
    logic [PW-1:0] fetch_pitch, fetch_size;

    int n_checks = 0;
    int n_fail   = 0;

    // expected timing values (minus one), mirrored from what the bench programs
    int hp_act, hp_tot, hp_bs, hp_be, hp_ss, hp_se;
    int vp_act, vp_tot, vp_bs, vp_be, vp_ss, vp_se;
    int exp_gfx;
    int exp_pitch, exp_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_timing_gen #(.AW(AW), .CW(CW), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pix_x(pix_x), .line_y(line_y), .de(de), .blank(blank),
        .hsync(hsync), .vsync(vsync), .fetch_req(fetch_req),
        .fetch_pitch(fetch_pitch), .fetch_size(fetch_size)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // drive a write from a falling edge; returns at the next falling edge
    task automatic write_reg(input int a, input logic [31:0] d);
        addr = AW'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input int a, output logic [31:0] d);
        addr = AW'(a); wr_en = 1'b0;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic outputs_idle(input string req);
        check(req, "idle outputs", {59'd0, de, blank, hsync, vsync, fetch_req}, 64'd0);
    endtask

    // compare every output against the model for raster cycle n
    task automatic check_cycle(input string tag, input int n);
        int h, v;
        logic e_de, e_bl, e_hs, e_vs, e_fr;
        h = n % (hp_tot + 1);
        v = (n / (hp_tot + 1)) % (vp_tot + 1);
        e_de = (exp_gfx != 0) && h <= hp_act && v <= vp_act;
        e_bl = (h > hp_bs && h <= hp_be) || (v > vp_bs && v <= vp_be);
        e_hs = h >= hp_ss && h <= hp_se;
        e_vs = v >= vp_ss && v <= vp_se;
        e_fr = (h == hp_act + 1) && (v < vp_act || v == vp_tot);
        check({tag, " R5"}, "pix_x/line_y", {32'(pix_x), 32'(line_y)}, {32'(h), 32'(v)});
        check({tag, " R6"}, "de", 64'(de), 64'(e_de));
        check({tag, " R7"}, "blank", 64'(blank), 64'(e_bl));
        check({tag, " R8"}, "hsync/vsync", {62'd0, hsync, vsync}, {62'd0, e_hs, e_vs});
        check({tag, " R9"}, "fetch_req", 64'(fetch_req), 64'(e_fr));
        if (e_fr)
            check({tag, " R9"}, "pitch/size", {32'(fetch_pitch), 32'(fetch_size)},
                  {32'(exp_pitch), 32'(exp_size)});
    endtask

    task automatic scan(input string tag, input int n0, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            check_cycle(tag, n0 + i);
            @(negedge clk);
        end
    endtask

    task automatic test_reset;
        logic [31:0] d;
        check("R1", "counters", {32'(pix_x), 32'(line_y)}, 64'd0);
        outputs_idle("R1");
        read_reg(0, d);  check("R1", "lock read", 64'(d), 64'd0);
        read_reg(1, d);  check("R1", "cfg read", 64'(d), 64'd0);
        read_reg(2, d);  check("R1", "hact read", 64'(d), 64'd0);
    endtask

    task automatic test_lock;
        logic [31:0] d;
        write_reg(1, 32'h3);                      // locked: must be dropped
        read_reg(1, d);  check("R2", "cfg while locked", 64'(d), 64'd0);
        repeat (4) @(negedge clk);
        check("R2", "counters after locked enable", {32'(pix_x), 32'(line_y)}, 64'd0);
        outputs_idle("R2");
        write_reg(0, 32'h0000_4758);
        read_reg(0, d);  check("R2", "lock open", 64'(d), 64'd1);
        write_reg(2, 32'h000F_0007);
        read_reg(2, d);  check("R3", "hact readback", 64'(d), 64'h000F_0007);
        write_reg(0, 32'h0000_4759);
        read_reg(0, d);  check("R2", "lock closed", 64'(d), 64'd0);
        write_reg(2, 32'h1234_5678);
        read_reg(2, d);  check("R2", "hact kept while locked", 64'(d), 64'h000F_0007);
        write_reg(0, 32'h0000_4758);
    endtask

    task automatic test_program;
        logic [31:0] d;
        logic [31:0] words [10];
        words[2] = 32'h000F_0007; words[3] = 32'h000F_0007; words[4] = 32'h000C_0009;
        words[5] = 32'h0007_0003; words[6] = 32'h0007_0003; words[7] = 32'h0006_0004;
        words[8] = 32'h0000_0050; words[9] = 32'h0000_0052;
        for (int a = 2; a < 10; a++) write_reg(a, words[a]);
        for (int a = 2; a < 10; a++) begin
            read_reg(a, d);
            check("R3", $sformatf("readback addr %0d", a), 64'(d), 64'(words[a]));
        end
        read_reg(15, d); check("R3", "unmapped read", 64'(d), 64'd0);
        hp_act = 7; hp_tot = 15; hp_bs = 7; hp_be = 15; hp_ss = 9; hp_se = 12;
        vp_act = 3; vp_tot = 7;  vp_bs = 3; vp_be = 7;  vp_ss = 4; vp_se = 6;
        exp_pitch = 'h50; exp_size = 'h52;
    endtask

    task automatic test_run;
        exp_gfx = 1;
        write_reg(1, 32'h3);
        scan("run", 0, 2 * 128 + 5);
    endtask

    task automatic test_disable;
        write_reg(1, 32'h0);
        outputs_idle("R4");
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            check("R4", "held counters", {32'(pix_x), 32'(line_y)}, 64'd0);
            outputs_idle("R4");
            @(negedge clk);
        end
    endtask

    task automatic test_gfx_off;
        exp_gfx = 0;
        write_reg(1, 32'h1);
        scan("gfx-off", 0, 128);
        write_reg(1, 32'h0);
        @(negedge clk);
    endtask

    // R10: a new total written mid-frame waits for the frame boundary
    task automatic test_shadow;
        exp_gfx = 1;
        write_reg(1, 32'h3);
        scan("R10 old", 0, 10);
        write_reg(2, 32'h0013_0007);
        scan("R10 old", 11, 117);
        hp_tot = 19;
        scan("R10 new", 0, 160 + 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_lock();
        test_program();
        test_run();
        test_disable();
        test_gfx_off();
        test_shadow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule